// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Filter

This block measures the phase relation between a divided feedback clock and a divided reference clock, both slow compared with a fast sampling clock. Each input is first brought into the sampling domain through a synchronizer chain. Only its rising edges are then used. Whichever input rises first sets a flag that drives an active-low correction pulse. The reference leading produces the "up" pulse, and the feedback leading produces the "down" pulse. When the other input rises, its own flag is set as well. With both flags high, a one-cycle reset clears them together. As a result, even coincident edges give a short pulse on both outputs, and the detector has no dead zone.

A raw indicator is the NAND of the two active-low pulses, so it is high while either correction pulse is active. A digital filter takes the place of an external RC network and comparator. It measures each high run of the raw indicator. The lock flag rises after a programmable number of consecutive comparisons whose runs stay at or below an error limit. A run that goes past the limit drops the lock flag at once. The lock flag is 1 while locked and 0 while unlocked.

Top module: `pfd_lock_top`

## Requirements
- R1: Reset state: while `rst_n` is low, and right after it is released, `up_n_o` and `dn_n_o` are 1, and `raw_ind_o` and `lock_o` are 0.
- R2: Only a rising edge of an input, seen after SYNC_STAGES synchronizer flops, starts or ends a measurement. Falling edges and steady levels produce no pulse.
- R3: If the reference rises k sample cycles before the feedback, `up_n_o` is low for k+1 cycles. `dn_n_o` is low for exactly 1 cycle, which is the last of those cycles.
- R4: If the feedback rises k cycles before the reference (k ≥ 1), `dn_n_o` is low for k+1 cycles and `up_n_o` is low for exactly 1 cycle at the end.
- R5: If both inputs rise in the same sample cycle, both `up_n_o` and `dn_n_o` are low for exactly one cycle.
- R6: Extra rising edges of the leading input before the lagging input arrives do not restart the measurement. The pulse width is counted from the first edge.
- R7: `raw_ind_o` is 1 exactly when `up_n_o` or `dn_n_o` is 0.
- R8: `lock_o` goes to 1 one cycle after the high run of `raw_ind_o` ends, for the LOCK_CYCLES-th consecutive comparison whose run is at most ERR_LIMIT cycles long.
- R9: Once `raw_ind_o` has been high for more than ERR_LIMIT consecutive cycles, `lock_o` is 0 on the next edge. The count of good comparisons restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous to `clk` |
| ref_clk_i | input | 1 | Divided reference clock, asynchronous to `clk` |
| up_n_o | output | 1 | Active-low up pulse (reference leads) |
| dn_n_o | output | 1 | Active-low down pulse (feedback leads) |
| raw_ind_o | output | 1 | NAND of the two pulses; 1 while either pulse is active |
| lock_o | output | 1 | Filtered lock flag; 1 = locked, 0 = unlocked |

## Verification
The bench builds the block with SYNC_STAGES=2, LOCK_CYCLES=4 and ERR_LIMIT=3. With these values a lock is won after four good comparisons, so the sequence can gain and lose lock several times within a few hundred cycles. A phase offset of only three cycles already crosses the error limit, so both sides of the kill threshold are exercised with short offsets. The double-edge case needs a ten-cycle offset, which is well past the limit, so it also tests the loss of lock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int IDX_FB  = 0;
    localparam int IDX_REF = 1;
    localparam int N_IN    = 2;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sh   = (cur_q.sh << 1) | STAGES'(d_i);
        nxt_d.prev = cur_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise_o = cur_q.sh[STAGES-1] & ~cur_q.prev;

    // A detected rising edge lasts a single sample cycle.
    p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fb_rise_i,
    input  logic ref_rise_i,
    output logic up_act_o,
    output logic dn_act_o
);
    pfd_flags_t flg_q, flg_d;
    logic       clr;

    always_comb begin
        clr      = flg_q.up & flg_q.dn;
        flg_d.up = (flg_q.up & ~clr) | ref_rise_i;
        flg_d.dn = (flg_q.dn & ~clr) | fb_rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign up_act_o = flg_q.up;
    assign dn_act_o = flg_q.dn;

    p_ref_sets_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise_i |=> up_act_o);
    p_fb_sets_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rise_i |=> dn_act_o);
    p_joint_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_act_o && dn_act_o && !ref_rise_i && !fb_rise_i) |=> (!up_act_o && !dn_act_o));
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
    parameter int LOCK_CYCLES = 16,
    parameter int ERR_LIMIT   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic locked_o
);
    localparam int RUN_MAX = ERR_LIMIT + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam int GOOD_W  = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [RUN_W-1:0]  run;
        logic [GOOD_W-1:0] good;
        logic              locked;
    } lk_t;

    lk_t lk_q, lk_d;

    always_comb begin
        lk_d = lk_q;
        if (raw_i) begin
            if (lk_q.run != RUN_W'(RUN_MAX)) lk_d.run = lk_q.run + RUN_W'(1);
            if (lk_q.run >= RUN_W'(ERR_LIMIT)) begin
                lk_d.locked = 1'b0;
                lk_d.good   = '0;
            end
        end else if (lk_q.run != '0) begin
            lk_d.run = '0;
            if (lk_q.run <= RUN_W'(ERR_LIMIT)) begin
                if (lk_q.good != GOOD_W'(LOCK_CYCLES)) lk_d.good = lk_q.good + GOOD_W'(1);
                if (lk_q.good >= GOOD_W'(LOCK_CYCLES - 1)) lk_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign locked_o = lk_q.locked;

    p_lock_after_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(!raw_i));
    p_kill_long_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i && lk_q.run >= RUN_W'(ERR_LIMIT)) |=> !locked_o);
    p_no_lock_over_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.run > RUN_W'(ERR_LIMIT)) |-> !locked_o);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 16,
    parameter int ERR_LIMIT   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_clk_i,
    input  logic ref_clk_i,
    output logic up_n_o,
    output logic dn_n_o,
    output logic raw_ind_o,
    output logic lock_o
);
    logic [N_IN-1:0] in_vec;
    logic [N_IN-1:0] rise_vec;
    logic            up_act, dn_act;

    assign in_vec[IDX_FB]  = fb_clk_i;
    assign in_vec[IDX_REF] = ref_clk_i;

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (in_vec[g]),
            .rise_o (rise_vec[g])
        );
    end

    pfd_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .fb_rise_i  (rise_vec[IDX_FB]),
        .ref_rise_i (rise_vec[IDX_REF]),
        .up_act_o   (up_act),
        .dn_act_o   (dn_act)
    );

    assign up_n_o    = ~up_act;
    assign dn_n_o    = ~dn_act;
    assign raw_ind_o = ~(up_n_o & dn_n_o);

    pfd_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES), .ERR_LIMIT(ERR_LIMIT)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (raw_ind_o),
        .locked_o (lock_o)
    );
endmodule

// File: tb/pfd_lock_top_tb_top.sv
module pfd_lock_top_tb_top;
    localparam int SYNC = 2;
    localparam int LOCK = 4;
    localparam int ERR  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb = 1'b0;
    logic ref_in = 1'b0;
    logic up_n, dn_n, raw, lock;

    always #4 clk = ~clk;

    pfd_lock_top #(.SYNC_STAGES(SYNC), .LOCK_CYCLES(LOCK), .ERR_LIMIT(ERR)) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_clk_i(fb), .ref_clk_i(ref_in),
        .up_n_o(up_n), .dn_n_o(dn_n), .raw_ind_o(raw), .lock_o(lock)
    );

    typedef struct {
        int up_w;
        int dn_w;
        bit lk;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int mgood = 0;
    bit mlock = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: pushes the expected result, then produces the two edges.
    task automatic compare(input bit ref_leads, input int k, input bit dbl, input string req);
        exp_t e;
        e.up_w = ref_leads ? k + 1 : 1;
        e.dn_w = ref_leads ? 1 : k + 1;
        if (k + 1 > ERR) begin mgood = 0; mlock = 0; end
        else begin mgood++; if (mgood >= LOCK) mlock = 1; end
        e.lk = mlock;
        e.req = req;
        q.push_back(e);
        @(negedge clk);
        if (k == 0) begin
            fb = 1'b1; ref_in = 1'b1;
        end else begin
            if (ref_leads) ref_in = 1'b1; else fb = 1'b1;
            if (dbl) begin
                repeat (3) @(negedge clk);
                if (ref_leads) ref_in = 1'b0; else fb = 1'b0;
                repeat (3) @(negedge clk);
                if (ref_leads) ref_in = 1'b1; else fb = 1'b1;
                repeat (k - 6) @(negedge clk);
            end else begin
                repeat (k) @(negedge clk);
            end
            if (ref_leads) fb = 1'b1; else ref_in = 1'b1;
        end
        repeat (k + 8) @(negedge clk);
        fb = 1'b0; ref_in = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // Monitor: measures pulse widths and checks the lock flag afterwards.
    int cu = 0, cd = 0;
    bit active = 0;
    bit lk_pend = 0;
    exp_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (lk_pend) begin
                lk_pend = 0;
                chk(lock == cur.lk, cur.req, "lock_o (R8/R9)", int'(lock), int'(cur.lk));
            end
            chk(raw == (!up_n || !dn_n), "R7", "raw_ind_o", int'(raw), int'(!up_n || !dn_n));
            if (!up_n || !dn_n) begin
                active = 1;
                if (!up_n) cu++;
                if (!dn_n) cd++;
            end else if (active) begin
                active = 0;
                if (q.size() == 0) begin
                    chk(0, "R2", "unexpected pulse, queue size", 0, 1);
                end else begin
                    cur = q.pop_front();
                    chk(cu == cur.up_w, cur.req, "up_n_o low width", cu, cur.up_w);
                    chk(cd == cur.dn_w, cur.req, "dn_n_o low width", cd, cur.dn_w);
                    lk_pend = 1;
                end
                cu = 0; cd = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(up_n == 1'b1, "R1", "up_n_o in reset", int'(up_n), 1);
        chk(dn_n == 1'b1, "R1", "dn_n_o in reset", int'(dn_n), 1);
        chk(raw == 1'b0, "R1", "raw_ind_o in reset", int'(raw), 0);
        chk(lock == 1'b0, "R1", "lock_o in reset", int'(lock), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(up_n && dn_n && !raw && !lock, "R1", "outputs after release", int'({up_n, dn_n, raw, lock}), 4'b1100);

        compare(1'b1, 2, 1'b0, "R3");   // good 1
        compare(1'b0, 1, 1'b0, "R4");   // good 2
        compare(1'b0, 0, 1'b0, "R5");   // good 3
        compare(1'b0, 2, 1'b0, "R8");   // good 4, lock rises
        compare(1'b1, 5, 1'b0, "R9");   // long run, lock falls
        compare(1'b0, 10, 1'b1, "R6");  // double edge of leader
        compare(1'b1, 1, 1'b0, "R3");
        compare(1'b0, 0, 1'b0, "R5");
        compare(1'b1, 2, 1'b0, "R8");
        compare(1'b0, 1, 1'b0, "R8");   // lock regained
        compare(1'b0, 3, 1'b0, "R9");   // just above the limit

        repeat (10) @(negedge clk);
        chk(q.size() == 0 && !active, "R2", "pending comparisons at end", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule